// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the output frequency, in Hz, of a phase-locked loop from its parent (reference) frequency and the divider settings currently programmed into it. A caller pulses `start` with the operands on the input ports. The block captures them and runs a multi-cycle integer datapath. It then raises `done` for one cycle, with the 64-bit result on `freqOut` and an `error` flag. Both outputs hold their values until the next `done`.

The operating mode selects the path:
- In the two bypass modes the answer is immediate: the parent frequency itself, or a fixed 32768 Hz low-power clock.
- In the locked modes the block divides the VCO rate down through two post dividers. The VCO rate is the parent frequency multiplied by the feedback divider and divided by the reference divider. A 24-bit fractional feedback term is added to it unless fractional operation is disabled.
- A single bit-serial restoring divider with a 64-bit dividend handles every quotient, one quotient bit per clock.
- A result that comes out odd is bumped to the next even value.

Top module: `pll_rate_calc`

## Requirements
- R1: With `mode` = 0 (bypass), `freqOut` equals `parentHz` zero-extended, with no even rounding, `error` = 0, and `done` one cycle after the accepting edge, whatever the divider fields hold.
- R2: With `mode` = 2 (low-power bypass), `freqOut` is 32768 and `error` = 0, with `done` one cycle after the accepting edge.
- R3: With `mode` = 1 and `fracDisable` = 1, the result is floor(floor(floor(parentHz·fbDiv / refDiv) / postDiv1) / postDiv2), computed with 64-bit intermediates, before the rounding of R5.
- R4: With `fracDisable` = 0, floor(parentHz·fracVal / refDiv) shifted right by 24 is added to the VCO rate before the post dividers. With `fracDisable` = 1, `fracVal` has no effect.
- R5: In modes 1 and 3, an odd final quotient is incremented by one, so bit 0 of a good result is always 0.
- R6: In modes 1 and 3, if any of `fbDiv`, `refDiv`, `postDiv1`, `postDiv2` is zero, the block reports `error` = 1 and `freqOut` = 0, with `done` one cycle after the accepting edge. In modes 0 and 2, zero fields raise no error.
- R7: A `start` sampled while `busy` is 1 is ignored and does not change the pending result.
- R8: For a computed result, `done` rises at clock edge 1 + 66·N, where edge 1 is the accepting edge. N is 3 with `fracDisable` = 1 and 4 with `fracDisable` = 0. `busy` is 1 from edge 1 until that edge and 0 otherwise.
- R9: After reset, `done`, `busy`, `error` and `freqOut` are 0. `done` lasts one cycle per accepted request, and `freqOut` and `error` change only together with `done`.
- R10: Mode 3 computes exactly as mode 1.
- R11: All operands are sampled on the accepting edge. Changing the input ports while `busy` is 1 does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| mode | input | 2 | 0 bypass, 1 locked, 2 low-power bypass, 3 locked |
| fracDisable | input | 1 | 1 = integer feedback, 0 = add fractional term |
| parentHz | input | 32 | Parent frequency in Hz |
| fbDiv | input | 12 | Feedback divider |
| refDiv | input | 6 | Reference divider |
| postDiv1 | input | 3 | First post divider |
| postDiv2 | input | 3 | Second post divider |
| fracVal | input | 24 | Fractional feedback term, 24 fraction bits |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| error | output | 1 | Zero divider field seen in a locked mode |
| freqOut | output | 64 | Computed frequency in Hz |

## Verification
A corrupted sequencer state or cycle counter shows first in the timing of the control outputs. Such a fault moves the `done` strobe away from edge 1 + 66·N, or drops `busy` early, and the bench compares both on every clock against a behavioural countdown. A wrong remainder, quotient or accumulator stays hidden until the strobe. It then shows as a wrong `freqOut` at exactly that cycle, and the bench computes the expected value from the arithmetic rules alone. Operand-capture faults are exposed by changing the inputs, and by pulsing `start` again, during a run.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_DEEP   = 2'd2;

  typedef enum logic [1:0] {PH_INT, PH_FRAC, PH_POST1, PH_POST2} phase_t;

  typedef struct packed {
    logic   latch;
    logic   load;
    logic   step;
    logic   capture;
    phase_t phase;
    logic   finPass;
    logic   finDeep;
    logic   finErr;
  } strobes_t;
endpackage

// File: rtl/pll_rate_ctrl.sv
module pll_rate_ctrl
  import pll_rate_pkg::*;
#(
  parameter int RES_W = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       fracDisable,
  input  logic       fieldZero,
  output strobes_t   strobes,
  output logic       busy
);
  localparam int CNT_W = $clog2(RES_W);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_CAPT} state_t;

  state_t             state;
  phase_t             phase;
  logic [CNT_W-1:0]   bitCnt;
  logic               fracOn;

  always_comb begin
    strobes       = '0;
    strobes.phase = phase;
    case (state)
      S_IDLE: if (start) begin
        if (mode == MODE_BYPASS)    strobes.finPass = 1'b1;
        else if (mode == MODE_DEEP) strobes.finDeep = 1'b1;
        else if (fieldZero)         strobes.finErr  = 1'b1;
        else                        strobes.latch   = 1'b1;
      end
      S_LOAD:  strobes.load    = 1'b1;
      S_RUN:   strobes.step    = 1'b1;
      default: strobes.capture = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= PH_INT;
      bitCnt <= '0;
      fracOn <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (strobes.latch) begin
          state  <= S_LOAD;
          phase  <= PH_INT;
          fracOn <= !fracDisable;
        end
        S_LOAD: begin
          state  <= S_RUN;
          bitCnt <= '0;
        end
        S_RUN: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(RES_W - 1)) state <= S_CAPT;
        end
        default: begin
          state <= S_LOAD;
          case (phase)
            PH_INT:   phase <= fracOn ? PH_FRAC : PH_POST1;
            PH_FRAC:  phase <= PH_POST1;
            PH_POST1: phase <= PH_POST2;
            default:  state <= S_IDLE;
          endcase
        end
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/pll_rate_dpath.sv
module pll_rate_dpath
  import pll_rate_pkg::*;
#(
  parameter int PAR_W  = 32,
  parameter int FB_W   = 12,
  parameter int REF_W  = 6,
  parameter int PD_W   = 3,
  parameter int FRAC_W = 24,
  parameter int RES_W  = 64,
  parameter int DEEP_HZ = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [PAR_W-1:0]  parentHz,
  input  logic [FB_W-1:0]   fbDiv,
  input  logic [REF_W-1:0]  refDiv,
  input  logic [PD_W-1:0]   postDiv1,
  input  logic [PD_W-1:0]   postDiv2,
  input  logic [FRAC_W-1:0] fracVal,
  output logic              done,
  output logic              error,
  output logic [RES_W-1:0]  freqOut
);
  logic [PAR_W-1:0]  pHz;
  logic [FB_W-1:0]   fbQ;
  logic [REF_W-1:0]  refQ;
  logic [PD_W-1:0]   pd1Q, pd2Q;
  logic [FRAC_W-1:0] fracQ;

  logic [RES_W-1:0]  remR, quoR, dvsR, accR;
  logic [RES_W:0]    remShift, remDiff;
  logic              fits;

  assign remShift = {remR, quoR[RES_W-1]};
  assign remDiff  = remShift - {1'b0, dvsR};
  assign fits     = (remShift >= {1'b0, dvsR});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pHz <= '0; fbQ <= '0; refQ <= '0; pd1Q <= '0; pd2Q <= '0; fracQ <= '0;
      remR <= '0; quoR <= '0; dvsR <= '0; accR <= '0;
      done <= 1'b0; error <= 1'b0; freqOut <= '0;
    end else begin
      done <= 1'b0;
      if (strobes.latch) begin
        pHz <= parentHz; fbQ <= fbDiv; refQ <= refDiv;
        pd1Q <= postDiv1; pd2Q <= postDiv2; fracQ <= fracVal;
      end
      if (strobes.load) begin
        remR <= '0;
        case (strobes.phase)
          PH_INT:   begin quoR <= RES_W'(pHz) * RES_W'(fbQ);   dvsR <= RES_W'(refQ); end
          PH_FRAC:  begin quoR <= RES_W'(pHz) * RES_W'(fracQ); dvsR <= RES_W'(refQ); end
          PH_POST1: begin quoR <= accR;                         dvsR <= RES_W'(pd1Q); end
          default:  begin quoR <= accR;                         dvsR <= RES_W'(pd2Q); end
        endcase
      end
      if (strobes.step) begin
        remR <= fits ? remDiff[RES_W-1:0] : remShift[RES_W-1:0];
        quoR <= {quoR[RES_W-2:0], fits};
      end
      if (strobes.capture) begin
        case (strobes.phase)
          PH_FRAC: accR <= accR + (quoR >> FRAC_W);
          PH_POST2: begin
            freqOut <= quoR + RES_W'(quoR[0]);
            error   <= 1'b0;
            done    <= 1'b1;
          end
          default: accR <= quoR;
        endcase
      end
      if (strobes.finPass) begin
        freqOut <= RES_W'(parentHz); error <= 1'b0; done <= 1'b1;
      end
      if (strobes.finDeep) begin
        freqOut <= RES_W'(DEEP_HZ); error <= 1'b0; done <= 1'b1;
      end
      if (strobes.finErr) begin
        freqOut <= '0; error <= 1'b1; done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_rate_pkg::*;
#(
  parameter int PAR_W  = 32,
  parameter int FB_W   = 12,
  parameter int REF_W  = 6,
  parameter int PD_W   = 3,
  parameter int FRAC_W = 24,
  parameter int RES_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              fracDisable,
  input  logic [PAR_W-1:0]  parentHz,
  input  logic [FB_W-1:0]   fbDiv,
  input  logic [REF_W-1:0]  refDiv,
  input  logic [PD_W-1:0]   postDiv1,
  input  logic [PD_W-1:0]   postDiv2,
  input  logic [FRAC_W-1:0] fracVal,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [RES_W-1:0]  freqOut
);
  strobes_t strobes;
  logic     fieldZero;

  assign fieldZero = (fbDiv == '0) || (refDiv == '0) || (postDiv1 == '0) || (postDiv2 == '0);

  pll_rate_ctrl #(.RES_W(RES_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .fracDisable(fracDisable), .fieldZero(fieldZero),
    .strobes(strobes), .busy(busy)
  );

  pll_rate_dpath #(
    .PAR_W(PAR_W), .FB_W(FB_W), .REF_W(REF_W), .PD_W(PD_W),
    .FRAC_W(FRAC_W), .RES_W(RES_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .parentHz(parentHz),
    .fbDiv(fbDiv), .refDiv(refDiv), .postDiv1(postDiv1), .postDiv2(postDiv2),
    .fracVal(fracVal), .done(done), .error(error), .freqOut(freqOut)
  );
endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
  parameter int PAR_W = 32,
  parameter int RES_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       mode,
  input logic [PAR_W-1:0] parentHz,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic [RES_W-1:0] freqOut
);
  logic [1:0]       accMode;
  logic [PAR_W-1:0] accParent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMode   <= '0;
      accParent <= '0;
    end else if (start && !busy) begin
      accMode   <= mode;
      accParent <= parentHz;
    end
  end

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && accMode == 2'd0) |-> (freqOut == RES_W'(accParent) && !error));

  assert_deep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && accMode == 2'd2) |-> (freqOut == RES_W'(32768) && !error));

  assert_even_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !error && accMode[0]) |-> !freqOut[0]);

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (freqOut == '0));

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(start) && !$past(busy)));

  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(freqOut) && $stable(error)));
endmodule

bind pll_rate_calc pll_rate_calc_chk #(.PAR_W(PAR_W), .RES_W(RES_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .mode(mode), .parentHz(parentHz),
  .busy(busy), .done(done), .error(error), .freqOut(freqOut)
);

// File: tb/tb_pll_rate_calc.sv
module tb_pll_rate_calc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic        fracDisable = 1'b1;
  logic [31:0] parentHz = '0;
  logic [11:0] fbDiv = '0;
  logic [5:0]  refDiv = '0;
  logic [2:0]  postDiv1 = '0;
  logic [2:0]  postDiv2 = '0;
  logic [23:0] fracVal = '0;
  logic        busy, done, error;
  logic [63:0] freqOut;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  string curReq = "R9";

  always #4 clk = ~clk;

  pll_rate_calc dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .fracDisable(fracDisable),
    .parentHz(parentHz), .fbDiv(fbDiv), .refDiv(refDiv), .postDiv1(postDiv1),
    .postDiv2(postDiv2), .fracVal(fracVal), .busy(busy), .done(done),
    .error(error), .freqOut(freqOut)
  );

  function automatic longint unsigned calc(input logic [1:0] md, input logic fdis,
      input longint unsigned p, input longint unsigned fb, input longint unsigned rf,
      input longint unsigned d1, input longint unsigned d2, input longint unsigned fr,
      output logic err);
    longint unsigned v;
    err = 1'b0;
    if (md == 2'd0) return p;
    if (md == 2'd2) return 64'd32768;
    if (fb == 0 || rf == 0 || d1 == 0 || d2 == 0) begin
      err = 1'b1;
      return 64'd0;
    end
    v = (p * fb) / rf;
    if (!fdis) v = v + (((p * fr) / rf) >> 24);
    v = (v / d1) / d2;
    if (v[0]) v = v + 1;
    return v;
  endfunction

  function automatic int latency(input logic [1:0] md, input logic fdis, input logic zero);
    if (md == 2'd0 || md == 2'd2 || zero) return 1;
    return fdis ? 1 + 66 * 3 : 1 + 66 * 4;
  endfunction

  // behavioural per-clock model
  int              mRem = 0;
  logic            mDone = 1'b0;
  longint unsigned mPend = 0, mRes = 0;
  logic            mPendErr = 1'b0, mErr = 1'b0;

  always @(posedge clk) begin
    logic e;
    longint unsigned r;
    int l;
    cycles++;
    if (!rstN) begin
      mRem = 0; mDone = 1'b0; mRes = 0; mErr = 1'b0;
    end else begin
      mDone = 1'b0;
      if (mRem == 0 && start) begin
        r = calc(mode, fracDisable, parentHz, fbDiv, refDiv, postDiv1, postDiv2, fracVal, e);
        l = latency(mode, fracDisable,
                    fbDiv == 0 || refDiv == 0 || postDiv1 == 0 || postDiv2 == 0);
        mPend = r; mPendErr = e; mRem = l - 1;
        if (mRem == 0) begin mDone = 1'b1; mRes = mPend; mErr = mPendErr; end
      end else if (mRem > 0) begin
        mRem--;
        if (mRem == 0) begin mDone = 1'b1; mRes = mPend; mErr = mPendErr; end
      end
    end
  end

  task automatic check64(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison (R8 timing, R9 holding)
  always @(negedge clk) begin
    if (rstN) begin
      check64("R8", {curReq, " busy"}, 64'(busy), 64'(mRem > 0));
      check64("R9", {curReq, " done"}, 64'(done), 64'(mDone));
      check64(curReq, "freqOut", freqOut, mRes);
      check64(curReq, "error", 64'(error), 64'(mErr));
    end
  end

  task automatic setOps(input logic [1:0] md, input logic fdis, input logic [31:0] p,
      input logic [11:0] fb, input logic [5:0] rf, input logic [2:0] d1,
      input logic [2:0] d2, input logic [23:0] fr);
    mode = md; fracDisable = fdis; parentHz = p; fbDiv = fb; refDiv = rf;
    postDiv1 = d1; postDiv2 = d2; fracVal = fr;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 400);
  endtask

  task automatic runCase(input string req, input logic [1:0] md, input logic fdis,
      input logic [31:0] p, input logic [11:0] fb, input logic [5:0] rf,
      input logic [2:0] d1, input logic [2:0] d2, input logic [23:0] fr);
    logic e;
    longint unsigned exp;
    int n;
    curReq = req;
    @(negedge clk);
    setOps(md, fdis, p, fb, rf, d1, d2, fr);
    start = 1'b1;
    exp = calc(md, fdis, p, fb, rf, d1, d2, fr, e);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (!done) begin
      int k;
      waitDone(k);
      n += k;
    end
    check64(req, "result", freqOut, exp);
    check64(req, "error flag", 64'(error), 64'(e));
    check64("R8", "latency", 64'(n),
            64'(latency(md, fdis, fb == 0 || rf == 0 || d1 == 0 || d2 == 0)));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check64("R9", "reset freqOut", freqOut, 0);
    check64("R9", "reset done", 64'(done), 0);
    check64("R9", "reset busy", 64'(busy), 0);
    check64("R9", "reset error", 64'(error), 0);
    rstN = 1'b1;

    runCase("R1", 2'd0, 1'b1, 32'd24000000, 12'd100, 6'd1, 3'd1, 3'd1, 24'd0);
    runCase("R1", 2'd0, 1'b0, 32'd24000001, 12'd0, 6'd0, 3'd0, 3'd0, 24'd5);
    runCase("R2", 2'd2, 1'b1, 32'd24000000, 12'd0, 6'd3, 3'd1, 3'd0, 24'd0);
    runCase("R3", 2'd1, 1'b1, 32'd24000000, 12'd100, 6'd1, 3'd2, 3'd1, 24'd0);
    runCase("R3", 2'd1, 1'b1, 32'd24000000, 12'd125, 6'd3, 3'd3, 3'd2, 24'd0);
    runCase("R3", 2'd1, 1'b1, 32'd4294967295, 12'd4095, 6'd63, 3'd7, 3'd7, 24'd0);
    runCase("R4", 2'd1, 1'b0, 32'd24000000, 12'd50, 6'd1, 3'd1, 3'd1, 24'h800000);
    runCase("R4", 2'd1, 1'b0, 32'd24000000, 12'd62, 6'd5, 3'd3, 3'd1, 24'hFFFFFF);
    runCase("R4", 2'd1, 1'b1, 32'd24000000, 12'd50, 6'd1, 3'd1, 3'd1, 24'h800000);
    runCase("R5", 2'd1, 1'b1, 32'd7, 12'd1, 6'd1, 3'd1, 3'd1, 24'd0);
    runCase("R5", 2'd1, 1'b1, 32'd1000001, 12'd3, 6'd1, 3'd1, 3'd1, 24'd0);
    runCase("R6", 2'd1, 1'b1, 32'd24000000, 12'd100, 6'd0, 3'd1, 3'd1, 24'd0);
    runCase("R6", 2'd3, 1'b0, 32'd24000000, 12'd100, 6'd1, 3'd1, 3'd0, 24'd0);
    runCase("R6", 2'd1, 1'b1, 32'd24000000, 12'd0, 6'd1, 3'd1, 3'd1, 24'd0);
    runCase("R10", 2'd3, 1'b0, 32'd26000000, 12'd77, 6'd2, 3'd2, 3'd3, 24'h123456);

    // R7 and R11: re-pulse start and change every operand during a run
    curReq = "R7";
    @(negedge clk);
    setOps(2'd1, 1'b1, 32'd24000000, 12'd99, 6'd1, 3'd1, 3'd1, 24'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    setOps(2'd0, 1'b0, 32'd11, 12'd3, 6'd2, 3'd5, 3'd4, 24'hABCDEF);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    curReq = "R11";
    waitDone(n);
    check64("R7", "second start ignored", freqOut, 64'd2376000000);
    check64("R11", "operands sampled at start", 64'(error), 64'd0);
    @(negedge clk);
    check64("R7", "no extra run", 64'(busy), 64'd0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule